// File: doc/BRIEF.md
# VGA Line and Frame Timing Generator

This block produces horizontal and vertical sync for 640-pixel-wide VGA modes. It runs from a system clock and advances one pixel position on every cycle in which the pixel-rate enable is high. It also gives three strobes to the rest of the display pipeline. The first marks the start of each line. The second marks a short window in the line where vertical sync begins. The third tells a downstream pixel engine that the visible area is about to start.

Configuration inputs set three things: the mode (a 480-line mode with active-low vertical sync, or a 400-line mode with active-high vertical sync), the line length in pixels, and the number of lines that follow the vertical sync region. The nominal setup is 800 pixels per line. That is 640 visible, 16 front porch, 96 sync and 48 back porch, at a 25.175 MHz pixel rate. A frame holds 525 lines in the 480-line mode and 449 lines in the 400-line mode. Line 0 of each frame is the first vertical sync line. The configuration is captured only at reset and at the end of a frame, so a change made mid-frame never breaks a line or a frame.

All outputs come from registers. A pixel position is counted as (h, v). The outputs seen after the enabled clock edge that consumes position (h, v) are the decode of (h, v).

Top module: `vga_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to position (0,0), drives `line_tick`, `vwin` and `act_start` low and `hsync_n` high, and drives `vsync` at its idle level for `cfg_mode`, which is 1 for mode 0 and 0 for mode 1. The first enabled edge after reset consumes position (0,0).
- R2: A line lasts `max(cfg_line_len, LINE_MIN)` enabled pixels, using the captured length.
- R3: `line_tick` is high for exactly the pixel at position h = 0 of every line.
- R4: `hsync_n` is low for positions 16 to 111 of every line and high elsewhere.
- R5: `act_start` is high for positions 152 to 159 of every line. The first visible pixel is position 160.
- R6: Vertical sync is active from position 16 of line 0 up to, but not including, position 16 of line 2. Its polarity comes from the captured mode: mode 0 (480 lines) drives `vsync` low when active, and mode 1 (400 lines) drives it high when active.
- R7: `vwin` is high for positions 144 to 215 of line 0 only.
- R8: A frame lasts `cfg_skip_lines + 3` lines, using the captured value.
- R9: Changes to `cfg_mode`, `cfg_line_len` and `cfg_skip_lines` take effect only at reset or at the edge that ends the last pixel of a frame.
- R10: In a cycle where `pix_en` is low and `rst` is low, no output changes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-rate enable; one pixel position per enabled cycle |
| cfg_mode | input | 1 | 0: 480-line mode (vsync active low), 1: 400-line mode (vsync active high) |
| cfg_line_len | input | LW | Pixels per line; values below LINE_MIN are raised to LINE_MIN |
| cfg_skip_lines | input | VW | Lines in the frame after the two sync lines, minus one |
| line_tick | output | 1 | High for position 0 of each line |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, polarity set by the captured mode |
| vwin | output | 1 | Window at positions 144..215 of line 0 |
| act_start | output | 1 | High at positions 152..159, before the visible area |

## Verification
The bench builds the block with LW = 12, VW = 10 and LINE_MIN = 256. It drives line lengths from 200 to 320 and skip counts of 0 to 6. Short lines and short frames like these let many complete frames, mode changes, mid-frame configuration writes and length clamping happen within a short run. One directed pass uses the full 800-pixel line in the 400-line mode, to cover the nominal horizontal layout with the opposite sync polarity. The pixel enable is randomized throughout, so every decode is also checked for holding its value during stalled cycles.

// File: rtl/vga_tm_pkg.sv
package vga_tm_pkg;
  typedef enum logic {
    MODE_480 = 1'b0,
    MODE_400 = 1'b1
  } vmode_e;

  // Pixel offsets inside a line
  localparam int unsigned HS_BEGIN = 16;
  localparam int unsigned HS_END   = 112;
  localparam int unsigned VW_BEGIN = 144;
  localparam int unsigned VW_END   = 216;
  localparam int unsigned AS_BEGIN = 152;
  localparam int unsigned AS_END   = 160;
  localparam int unsigned VS_EDGE  = 16;
  // Lines covered by vertical sync
  localparam int unsigned VS_LINES = 2;

  function automatic logic vs_idle(input vmode_e m);
    return (m == MODE_480);
  endfunction
endpackage

// File: rtl/vga_cfg_shadow.sv
module vga_cfg_shadow #(
  parameter int LW = 12,
  parameter int VW = 10,
  parameter int LINE_MIN = 256,
  localparam int VCW = VW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 cfg_mode,
  input  logic [LW-1:0]        cfg_line_len,
  input  logic [VW-1:0]        cfg_skip_lines,
  output vga_tm_pkg::vmode_e   mode_q,
  output logic [LW-1:0]        len_q,
  output logic [VCW-1:0]       last_q
);
  import vga_tm_pkg::*;

  logic [LW-1:0]  len_eff;
  logic [VCW-1:0] last_eff;

  always_comb begin
    len_eff  = (cfg_line_len < LW'(LINE_MIN)) ? LW'(LINE_MIN) : cfg_line_len;
    last_eff = VCW'(cfg_skip_lines) + VCW'(VS_LINES);
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      mode_q <= vmode_e'(cfg_mode);
      len_q  <= len_eff;
      last_q <= last_eff;
    end
  end
endmodule

// File: rtl/vga_hcount.sv
module vga_hcount #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] len,
  output logic [LW-1:0] hcnt,
  output logic          line_end,
  output logic          line_tick,
  output logic          hsync_n,
  output logic          act_start
);
  import vga_tm_pkg::*;

  logic at_last;

  always_comb begin
    at_last  = (hcnt == len - LW'(1));
    line_end = en && at_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt      <= '0;
      line_tick <= 1'b0;
      hsync_n   <= 1'b1;
      act_start <= 1'b0;
    end else if (en) begin
      hcnt      <= at_last ? '0 : hcnt + LW'(1);
      line_tick <= (hcnt == '0);
      hsync_n   <= !((hcnt >= LW'(HS_BEGIN)) && (hcnt < LW'(HS_END)));
      act_start <= (hcnt >= LW'(AS_BEGIN)) && (hcnt < LW'(AS_END));
    end
  end
endmodule

// File: rtl/vga_vcount.sv
module vga_vcount #(
  parameter int LW = 12,
  parameter int VCW = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_mode,
  input  logic               en,
  input  logic               line_end,
  input  logic [LW-1:0]      hcnt,
  input  logic [VCW-1:0]     last,
  input  vga_tm_pkg::vmode_e mode,
  output logic               frame_end,
  output logic               vsync,
  output logic               vwin
);
  import vga_tm_pkg::*;

  logic [VCW-1:0] vcnt;
  logic           vs_act;
  logic           win;

  always_comb begin
    frame_end = line_end && (vcnt == last);
    vs_act = ((vcnt == '0) && (hcnt >= LW'(VS_EDGE))) ||
             ((vcnt != '0) && (vcnt < VCW'(VS_LINES))) ||
             ((vcnt == VCW'(VS_LINES)) && (hcnt < LW'(VS_EDGE)));
    win = (vcnt == '0) && (hcnt >= LW'(VW_BEGIN)) && (hcnt < LW'(VW_END));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt  <= '0;
      vsync <= vs_idle(vmode_e'(rst_mode));
      vwin  <= 1'b0;
    end else if (en) begin
      if (line_end) vcnt <= frame_end ? '0 : vcnt + VCW'(1);
      vsync <= vs_act ^ vs_idle(mode);
      vwin  <= win;
    end
  end
endmodule

// File: rtl/vga_timing_gen.sv
module vga_timing_gen #(
  parameter int LW = 12,
  parameter int VW = 10,
  parameter int LINE_MIN = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          cfg_mode,
  input  logic [LW-1:0] cfg_line_len,
  input  logic [VW-1:0] cfg_skip_lines,
  output logic          line_tick,
  output logic          hsync_n,
  output logic          vsync,
  output logic          vwin,
  output logic          act_start
);
  import vga_tm_pkg::*;
  localparam int VCW = VW + 1;

  vmode_e         mode_q;
  logic [LW-1:0]  len_q;
  logic [VCW-1:0] last_q;
  logic [LW-1:0]  hcnt;
  logic           line_end;
  logic           frame_end;

  vga_cfg_shadow #(.LW(LW), .VW(VW), .LINE_MIN(LINE_MIN)) u_shadow (
    .clk(clk), .rst(rst), .load(frame_end),
    .cfg_mode(cfg_mode), .cfg_line_len(cfg_line_len), .cfg_skip_lines(cfg_skip_lines),
    .mode_q(mode_q), .len_q(len_q), .last_q(last_q)
  );

  vga_hcount #(.LW(LW)) u_h (
    .clk(clk), .rst(rst), .en(pix_en), .len(len_q),
    .hcnt(hcnt), .line_end(line_end),
    .line_tick(line_tick), .hsync_n(hsync_n), .act_start(act_start)
  );

  vga_vcount #(.LW(LW), .VCW(VCW)) u_v (
    .clk(clk), .rst(rst), .rst_mode(cfg_mode), .en(pix_en),
    .line_end(line_end), .hcnt(hcnt), .last(last_q), .mode(mode_q),
    .frame_end(frame_end), .vsync(vsync), .vwin(vwin)
  );
endmodule

// File: rtl/vga_timing_chk.sv
module vga_timing_chk #(
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic          line_tick,
  input logic          hsync_n,
  input logic          vsync,
  input logic          vwin,
  input logic          act_start,
  input logic [LW-1:0] hcnt,
  input logic [LW-1:0] len_q,
  input logic          mode_q
);
  // R3: the tick lasts one enabled pixel
  p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
    (line_tick && pix_en) |=> !line_tick);

  // R4: horizontal sync is idle at line start
  p_hsync_idle_tick_r4: assert property (@(posedge clk) disable iff (rst)
    line_tick |-> hsync_n);

  // R5: the visible-area strobe rises after horizontal sync has ended
  p_act_after_sync_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(act_start) |-> hsync_n);

  // R6, R7: the window lies inside active vertical sync
  p_vwin_in_vsync_r7: assert property (@(posedge clk) disable iff (rst)
    vwin |-> (vsync == mode_q));

  // R10: stalled cycles change nothing
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (!pix_en && !rst) |=> ($stable(line_tick) && $stable(hsync_n) &&
      $stable(vsync) && $stable(vwin) && $stable(act_start)));

  // R2: the pixel counter stays inside the captured line length
  p_hcnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    hcnt < len_q);
endmodule

bind vga_timing_gen vga_timing_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .line_tick(line_tick),
  .hsync_n(hsync_n), .vsync(vsync), .vwin(vwin), .act_start(act_start),
  .hcnt(hcnt), .len_q(len_q), .mode_q(mode_q)
);

// File: tb/sim_vga_timing_gen.sv
module sim_vga_timing_gen;
  localparam int LW = 12;
  localparam int VW = 10;
  localparam int LINE_MIN = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic cfg_mode = 1'b0;
  logic [LW-1:0] cfg_line_len = LW'(260);
  logic [VW-1:0] cfg_skip_lines = VW'(3);
  logic line_tick, hsync_n, vsync, vwin, act_start;

  always #5 clk = ~clk;

  vga_timing_gen #(.LW(LW), .VW(VW), .LINE_MIN(LINE_MIN)) u0 (
    .clk(clk), .rst(rst), .pix_en(pix_en), .cfg_mode(cfg_mode),
    .cfg_line_len(cfg_line_len), .cfg_skip_lines(cfg_skip_lines),
    .line_tick(line_tick), .hsync_n(hsync_n), .vsync(vsync),
    .vwin(vwin), .act_start(act_start)
  );

  int n_chk = 0, n_fail = 0;
  // next configuration to present
  int nx_mode = 0, nx_len = 260, nx_skip = 3;
  // model state
  int m_h = 0, m_v = 0, sh_len = 260, sh_last = 5, sh_mode = 0;
  bit e_tick = 0, e_hs = 1, e_vs = 1, e_vw = 0, e_as = 0;
  bit valid = 0, prev_en = 0, prev_rst = 1, pending = 0;
  int en_cnt = 0, tick_at = 0, last_wrap_len = 0, last_frame_lines = 0, lines = 0;
  bit had_tick = 0, had_vw = 0, seen_tick = 0, seen_vw = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    return (l < LINE_MIN) ? LINE_MIN : l;
  endfunction

  task automatic compare();
    string rq;
    rq = prev_rst ? "R1" : (prev_en ? "" : "R10");
    chk(line_tick == e_tick, (rq == "") ? "R3" : rq, "line_tick", int'(line_tick), int'(e_tick));
    chk(hsync_n == e_hs, (rq == "") ? "R4" : rq, "hsync_n", int'(hsync_n), int'(e_hs));
    chk(act_start == e_as, (rq == "") ? "R5" : rq, "act_start", int'(act_start), int'(e_as));
    chk(vsync == e_vs, (rq == "") ? "R6" : rq, "vsync", int'(vsync), int'(e_vs));
    chk(vwin == e_vw, (rq == "") ? "R7" : rq, "vwin", int'(vwin), int'(e_vw));
    if (line_tick && !seen_tick) begin
      if (had_tick)
        chk(en_cnt - tick_at == last_wrap_len, pending ? "R9" : "R2", "line length",
            en_cnt - tick_at, last_wrap_len);
      tick_at = en_cnt; had_tick = 1; lines++;
    end
    if (vwin && !seen_vw) begin
      if (had_vw)
        chk(lines == last_frame_lines, pending ? "R9" : "R8", "frame lines",
            lines, last_frame_lines);
      lines = 0; had_vw = 1;
    end
    seen_tick = line_tick;
    seen_vw = vwin;
  endtask

  task automatic step(input bit e, input bit r);
    bit act;
    @(negedge clk);
    if (valid) compare();
    rst = r; pix_en = e;
    cfg_mode = nx_mode[0];
    cfg_line_len = LW'(nx_len);
    cfg_skip_lines = VW'(nx_skip);
    pending = (eff_len(nx_len) != sh_len) || (nx_skip + 2 != sh_last) || (nx_mode != sh_mode);
    if (r) begin
      m_h = 0; m_v = 0;
      sh_len = eff_len(nx_len); sh_last = nx_skip + 2; sh_mode = nx_mode;
      e_tick = 0; e_hs = 1; e_as = 0; e_vw = 0; e_vs = (nx_mode == 0);
      had_tick = 0; had_vw = 0; lines = 0;
    end else if (e) begin
      act = (m_v == 0 && m_h >= 16) || (m_v == 1) || (m_v == 2 && m_h < 16);
      e_tick = (m_h == 0);
      e_hs = !(m_h >= 16 && m_h < 112);
      e_as = (m_h >= 152 && m_h < 160);
      e_vw = (m_v == 0 && m_h >= 144 && m_h < 216);
      e_vs = (sh_mode == 1) ? act : !act;
      en_cnt++;
      if (m_h == sh_len - 1) begin
        m_h = 0;
        last_wrap_len = sh_len;
        if (m_v == sh_last) begin
          last_frame_lines = sh_last + 1;
          m_v = 0;
          sh_len = eff_len(nx_len); sh_last = nx_skip + 2; sh_mode = nx_mode;
        end else m_v++;
      end else m_h++;
    end
    prev_en = e; prev_rst = r; valid = 1;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset in mode 0, then in mode 1
    step(0, 1); step(0, 1);
    nx_mode = 1; step(0, 1); step(0, 1);
    nx_mode = 0; step(0, 1); step(1, 0);
    // Random run with configuration changes mid-frame (R9) and clamping (R2)
    for (int i = 0; i < 60000; i++) begin
      if ((i % 1500) == 700) begin
        nx_mode = int'($urandom_range(0, 1));
        nx_len = int'($urandom_range(200, 320));
        nx_skip = int'($urandom_range(0, 6));
      end
      if (i == 30000) begin
        step(0, 1); step(1, 1);
      end
      step(($urandom_range(0, 3) != 0), 0);
    end
    // Directed: full 800-pixel line, 400-line mode, short frame
    nx_mode = 1; nx_len = 800; nx_skip = 1;
    step(0, 1);
    for (int i = 0; i < 14000; i++) step(1, 0);
    // Directed: length below the minimum, skip 0 (R2, R8)
    nx_mode = 0; nx_len = 100; nx_skip = 0;
    step(0, 1);
    for (int i = 0; i < 6000; i++) step(($urandom_range(0, 1) != 0), 0);
    step(0, 0);
    summary();
    $finish;
  end
endmodule